// File: doc/BRIEF.md
# LCD Controller Register File

This block is the software-visible register file of a colour LCD controller. It sits on a simple one-cycle memory-mapped bus over a 4 KB window. It holds the four display timing words, the upper and lower frame base addresses, a control word, an interrupt mask and the raw interrupt status. From these it produces the signals the rest of the controller uses: the active column count, the active row count, the pixel depth code, the colour and byte-order flags and a combined display enable.

A strap input chooses between two register layouts. The layouts differ in two ways: the word offsets of the control and interrupt-mask registers are exchanged, and the identification bytes at the top of the window change. Bus reads return data in the same cycle as the request. A write takes effect at the clock edge that ends the bus cycle. The palette range is not stored here. It is decoded and forwarded with a write strobe and an entry index, and its read data is passed back to the bus. Interrupt events come in as single-cycle pulses, one per status bit. The interrupt output is the OR of the status bits that the mask lets through.

Any accepted write moves a two-state invalidate machine from `INV_IDLE` to `INV_PULSE` for exactly one cycle. The transition `INV_IDLE -> INV_PULSE` is taken on a write. `INV_PULSE -> INV_PULSE` is taken on a back-to-back write. `INV_PULSE -> INV_IDLE` is taken when there is no write. The `invalidate` output is high while the machine is in `INV_PULSE`.

Top module: `lcdc_regfile`

## Requirements
- R1: After reset every stored register reads zero, and `disp_cols`, `disp_rows`, `depth_code`, `disp_enable`, `irq` and `invalidate` are all 0.
- R2: Word offsets 0 to 3 (byte address bits 11:2) hold timing words 0 to 3, word 4 holds the upper base and word 5 holds the lower base. Each reads back the full 32-bit value last written. The upper and lower bases also drive `upper_base` and `lower_base`.
- R3: Words 11 and 12 read the upper and lower base. Writes to words 8, 9, 11 and 12, and to any undefined offset, change nothing. Undefined offsets and word 10 read zero.
- R4: With `alt_layout`=0, word 6 is the interrupt mask and word 7 is the control register. With `alt_layout`=1 the two offsets are exchanged, for both reads and writes.
- R5: In the cycle after a write to word 0, `disp_cols` equals ((wdata AND 0xFC) + 4) * 4.
- R6: In the cycle after a write to word 1, `disp_rows` equals wdata[9:0] + 1. `disp_rows` holds its value otherwise.
- R7: The control register drives the following outputs. `depth_code` is bits 3:1. `pix_bgr` is bit 8. `be_bytes` is bit 9. `be_pixels` is bit 10. `disp_enable` is bit 0 AND bit 11.
- R8: A pulse on `irq_event[k]` sets raw status bit k, which reads at word 8. A write to word 10 clears each raw bit that is 1 in wdata. A set wins over a clear of the same bit in the same cycle.
- R9: Word 9 reads raw status AND mask, and `irq` is the OR of those bits.
- R10: Byte addresses 0xFE0 to 0xFFC return one identification byte per word, in bits 7:0, indexed by address bits 4:2. With `alt_layout`=0 the bytes are 10,11,04,00,0D,F0,05,B1 (hex). With `alt_layout`=1 they are 11,11,24,00,0D,F0,05,B1.
- R11: Byte addresses 0x200 to 0x3FF form the palette range. There `pal_index` is address bits 8:2, `pal_we` is high during a write, and reads return `pal_rdata`. `pal_we` is low for reads and for all other addresses. A palette write changes no stored register.
- R12: `invalidate` is high for exactly the cycle after each accepted write, to any offset. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_layout | input | 1 | Layout strap: swaps control and mask offsets and selects the identification set |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| pal_we | output | 1 | Palette entry write strobe |
| pal_index | output | 7 | Palette entry index |
| pal_rdata | input | 32 | Palette entry read data |
| irq_event | input | 5 | One-cycle event pulses, one per status bit |
| irq | output | 1 | Combined masked interrupt |
| disp_cols | output | 11 | Active columns |
| disp_rows | output | 11 | Active rows |
| depth_code | output | 3 | Pixel depth code |
| disp_enable | output | 1 | Display enabled (enable and power bits) |
| pix_bgr | output | 1 | Swap red and blue |
| be_bytes | output | 1 | Big-endian byte order |
| be_pixels | output | 1 | Big-endian pixel order |
| upper_base | output | 32 | Upper frame base address |
| lower_base | output | 32 | Lower frame base address |
| invalidate | output | 1 | One-cycle pulse after any write |

## Verification
The bench builds the block with its default parameters: a 12-bit address, 32-bit data, five interrupt bits, a 6-bit column field and a 10-bit row field. With these the largest column count (1024) and the largest row count (1024) both fit their 11-bit outputs, so the saturating corners of both formulas can be checked exactly. Five status bits allow partial clears, a clear that overlaps a same-cycle set, and masks that let through only some of the pending events. The strap is toggled during the run, so the swapped offsets and both identification sets are read against the same stored contents.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

    localparam int NUM_TIMING     = 4;
    localparam int PAL_IDX_W      = 7;
    localparam int PAL_FIRST_WORD = 128;
    localparam int ID_WORDS       = 8;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_BGR_BIT   = 8;
    localparam int CTRL_BEB_BIT   = 9;
    localparam int CTRL_BEP_BIT   = 10;
    localparam int CTRL_PWR_BIT   = 11;

    typedef enum logic [3:0] {
        RS_NONE, RS_TIM0, RS_TIM1, RS_TIM2, RS_TIM3,
        RS_UPBASE, RS_LPBASE, RS_MASK, RS_CTRL,
        RS_RAW, RS_MASKED, RS_CLEAR, RS_UPCUR, RS_LPCUR,
        RS_PAL, RS_ID
    } reg_sel_e;

    typedef enum logic {
        INV_IDLE,
        INV_PULSE
    } inv_state_e;

    function automatic logic [7:0] id_byte(input logic alt, input logic [2:0] idx);
        logic [7:0] b;
        unique case (idx)
            3'd0:    b = alt ? 8'h11 : 8'h10;
            3'd1:    b = 8'h11;
            3'd2:    b = alt ? 8'h24 : 8'h04;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/lcdc_decode.sv
module lcdc_decode
    import lcdc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 alt_i,
    output reg_sel_e             sel_o,
    output logic [PAL_IDX_W-1:0] pal_idx_o
);
    localparam int WORD_W        = ADDR_W - 2;
    localparam int ID_FIRST_WORD = (1 << WORD_W) - ID_WORDS;
    localparam int PAL_LAST_WORD = PAL_FIRST_WORD + (1 << PAL_IDX_W) - 1;

    logic [WORD_W-1:0] word;
    logic              unused_lo;

    assign word      = addr_i[ADDR_W-1:2];
    assign unused_lo = ^addr_i[1:0];
    assign pal_idx_o = addr_i[PAL_IDX_W+1:2];

    always_comb begin
        if (word >= WORD_W'(ID_FIRST_WORD)) begin
            sel_o = RS_ID;
        end else if (word >= WORD_W'(PAL_FIRST_WORD) && word <= WORD_W'(PAL_LAST_WORD)) begin
            sel_o = RS_PAL;
        end else begin
            unique case (word)
                WORD_W'(0):  sel_o = RS_TIM0;
                WORD_W'(1):  sel_o = RS_TIM1;
                WORD_W'(2):  sel_o = RS_TIM2;
                WORD_W'(3):  sel_o = RS_TIM3;
                WORD_W'(4):  sel_o = RS_UPBASE;
                WORD_W'(5):  sel_o = RS_LPBASE;
                WORD_W'(6):  sel_o = alt_i ? RS_CTRL : RS_MASK;
                WORD_W'(7):  sel_o = alt_i ? RS_MASK : RS_CTRL;
                WORD_W'(8):  sel_o = RS_RAW;
                WORD_W'(9):  sel_o = RS_MASKED;
                WORD_W'(10): sel_o = RS_CLEAR;
                WORD_W'(11): sel_o = RS_UPCUR;
                WORD_W'(12): sel_o = RS_LPCUR;
                default:     sel_o = RS_NONE;
            endcase
        end
    end
endmodule

// File: rtl/lcdc_irq.sv
module lcdc_irq #(
    parameter int IRQ_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] event_i,
    input  logic             mask_we,
    input  logic             clr_we,
    input  logic [IRQ_W-1:0] wdata_i,
    output logic [IRQ_W-1:0] raw_o,
    output logic [IRQ_W-1:0] mask_o,
    output logic [IRQ_W-1:0] masked_o,
    output logic             irq_o
);
    logic [IRQ_W-1:0] clr_bits;

    assign clr_bits = clr_we ? wdata_i : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_o  <= '0;
            mask_o <= '0;
        end else begin
            raw_o <= (raw_o & ~clr_bits) | event_i;
            if (mask_we) begin
                mask_o <= wdata_i;
            end
        end
    end

    assign masked_o = raw_o & mask_o;
    assign irq_o    = |masked_o;
endmodule

// File: rtl/lcdc_geom.sv
module lcdc_geom #(
    parameter int COL_FIELD_W = 6,
    parameter int ROW_FIELD_W = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   col_we,
    input  logic                   row_we,
    input  logic [COL_FIELD_W-1:0] col_field,
    input  logic [ROW_FIELD_W-1:0] row_field,
    output logic [COL_FIELD_W+4:0] cols_o,
    output logic [ROW_FIELD_W:0]   rows_o
);
    localparam int COL_W = COL_FIELD_W + 5;
    localparam int ROW_W = ROW_FIELD_W + 1;

    logic [COL_W-1:0] cols_d;
    logic [ROW_W-1:0] rows_d;

    // field counts groups of four pixels plus one group, times four
    assign cols_d = {(COL_W - 4)'({1'b0, col_field} + 1'b1), 4'b0000};
    assign rows_d = ROW_W'({1'b0, row_field} + 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cols_o <= '0;
            rows_o <= '0;
        end else begin
            if (col_we) cols_o <= cols_d;
            if (row_we) rows_o <= rows_d;
        end
    end
endmodule

// File: rtl/lcdc_regfile.sv
module lcdc_regfile
    import lcdc_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int IRQ_W       = 5,
    parameter int COL_FIELD_W = 6,
    parameter int ROW_FIELD_W = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alt_layout,
    input  logic                   bus_sel,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic                   pal_we,
    output logic [PAL_IDX_W-1:0]   pal_index,
    input  logic [DATA_W-1:0]      pal_rdata,
    input  logic [IRQ_W-1:0]       irq_event,
    output logic                   irq,
    output logic [COL_FIELD_W+4:0] disp_cols,
    output logic [ROW_FIELD_W:0]   disp_rows,
    output logic [2:0]             depth_code,
    output logic                   disp_enable,
    output logic                   pix_bgr,
    output logic                   be_bytes,
    output logic                   be_pixels,
    output logic [DATA_W-1:0]      upper_base,
    output logic [DATA_W-1:0]      lower_base,
    output logic                   invalidate
);
    reg_sel_e                acc_sel;
    logic                    wr_en;
    logic                    tim_hit;
    logic [NUM_TIMING-1:0]   tim_we;
    logic [DATA_W-1:0]       timing_q [NUM_TIMING];
    logic [DATA_W-1:0]       ctrl_q;
    logic [IRQ_W-1:0]        raw_q;
    logic [IRQ_W-1:0]        mask_q;
    logic [IRQ_W-1:0]        masked_q;
    logic [DATA_W-1:0]       rd_mux;
    inv_state_e              inv_state;
    inv_state_e              inv_next;

    lcdc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i    (bus_addr),
        .alt_i     (alt_layout),
        .sel_o     (acc_sel),
        .pal_idx_o (pal_index)
    );

    assign wr_en   = bus_sel & bus_wr;
    assign pal_we  = wr_en & (acc_sel == RS_PAL);
    assign tim_hit = (acc_sel == RS_TIM0) || (acc_sel == RS_TIM1) ||
                     (acc_sel == RS_TIM2) || (acc_sel == RS_TIM3);

    for (genvar g = 0; g < NUM_TIMING; g++) begin : g_timing
        assign tim_we[g] = wr_en & tim_hit & (bus_addr[3:2] == 2'(g));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                timing_q[g] <= '0;
            end else if (tim_we[g]) begin
                timing_q[g] <= bus_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_base <= '0;
            lower_base <= '0;
            ctrl_q     <= '0;
        end else if (wr_en) begin
            if (acc_sel == RS_UPBASE) upper_base <= bus_wdata;
            if (acc_sel == RS_LPBASE) lower_base <= bus_wdata;
            if (acc_sel == RS_CTRL)   ctrl_q     <= bus_wdata;
        end
    end

    lcdc_irq #(.IRQ_W(IRQ_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .event_i  (irq_event),
        .mask_we  (wr_en & (acc_sel == RS_MASK)),
        .clr_we   (wr_en & (acc_sel == RS_CLEAR)),
        .wdata_i  (bus_wdata[IRQ_W-1:0]),
        .raw_o    (raw_q),
        .mask_o   (mask_q),
        .masked_o (masked_q),
        .irq_o    (irq)
    );

    lcdc_geom #(.COL_FIELD_W(COL_FIELD_W), .ROW_FIELD_W(ROW_FIELD_W)) u_geom (
        .clk       (clk),
        .rst_n     (rst_n),
        .col_we    (tim_we[0]),
        .row_we    (tim_we[1]),
        .col_field (bus_wdata[COL_FIELD_W+1:2]),
        .row_field (bus_wdata[ROW_FIELD_W-1:0]),
        .cols_o    (disp_cols),
        .rows_o    (disp_rows)
    );

    assign depth_code  = ctrl_q[3:1];
    assign pix_bgr     = ctrl_q[CTRL_BGR_BIT];
    assign be_bytes    = ctrl_q[CTRL_BEB_BIT];
    assign be_pixels   = ctrl_q[CTRL_BEP_BIT];
    assign disp_enable = ctrl_q[CTRL_EN_BIT] & ctrl_q[CTRL_PWR_BIT];

    always_comb begin
        unique case (acc_sel)
            RS_TIM0:   rd_mux = timing_q[0];
            RS_TIM1:   rd_mux = timing_q[1];
            RS_TIM2:   rd_mux = timing_q[2];
            RS_TIM3:   rd_mux = timing_q[3];
            RS_UPBASE: rd_mux = upper_base;
            RS_LPBASE: rd_mux = lower_base;
            RS_MASK:   rd_mux = DATA_W'(mask_q);
            RS_CTRL:   rd_mux = ctrl_q;
            RS_RAW:    rd_mux = DATA_W'(raw_q);
            RS_MASKED: rd_mux = DATA_W'(masked_q);
            RS_CLEAR:  rd_mux = '0;
            RS_UPCUR:  rd_mux = upper_base;
            RS_LPCUR:  rd_mux = lower_base;
            RS_PAL:    rd_mux = pal_rdata;
            RS_ID:     rd_mux = DATA_W'(id_byte(alt_layout, bus_addr[4:2]));
            RS_NONE:   rd_mux = '0;
        endcase
    end

    assign bus_rdata = bus_sel ? rd_mux : '0;

    // invalidate machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_state <= INV_IDLE;
        end else begin
            inv_state <= inv_next;
        end
    end

    // invalidate machine: next state and output
    always_comb begin
        unique case (inv_state)
            INV_IDLE:  inv_next = wr_en ? INV_PULSE : INV_IDLE;
            INV_PULSE: inv_next = wr_en ? INV_PULSE : INV_IDLE;
        endcase
        invalidate = (inv_state == INV_PULSE);
    end
endmodule

// File: rtl/lcdc_regfile_chk.sv
module lcdc_regfile_chk #(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int IRQ_W       = 5,
    parameter int COL_FIELD_W = 6,
    parameter int ROW_FIELD_W = 10
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_sel,
    input logic                   bus_wr,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [DATA_W-1:0]      bus_wdata,
    input logic [IRQ_W-1:0]       irq_event,
    input logic [IRQ_W-1:0]       raw_q,
    input logic [COL_FIELD_W+4:0] disp_cols,
    input logic [ROW_FIELD_W:0]   disp_rows,
    input logic                   disp_enable,
    input logic                   invalidate
);
    // R12
    inv_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr) |=> invalidate);

    // R12
    inv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> !invalidate);

    // R5
    cols_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr[ADDR_W-1:2] == '0) |=>
        (int'(disp_cols) == (int'($past(bus_wdata[7:0])) / 4 + 1) * 16));

    // R6
    rows_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(1)) |=> $stable(disp_rows));

    // R8
    event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_event) |=> ((raw_q & $past(irq_event)) == $past(irq_event)));

    // R7
    enable_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_enable) |-> $past(bus_sel && bus_wr));
endmodule

bind lcdc_regfile lcdc_regfile_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_W(IRQ_W),
    .COL_FIELD_W(COL_FIELD_W), .ROW_FIELD_W(ROW_FIELD_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .irq_event   (irq_event),
    .raw_q       (raw_q),
    .disp_cols   (disp_cols),
    .disp_rows   (disp_rows),
    .disp_enable (disp_enable),
    .invalidate  (invalidate)
);

// File: tb/test_lcdc_regfile.sv
module test_lcdc_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int NIRQ       = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alt_layout = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pal_we;
    logic [6:0]  pal_index;
    logic [31:0] pal_rdata;
    logic [NIRQ-1:0] irq_event = '0;
    logic        irq;
    logic [10:0] disp_cols;
    logic [10:0] disp_rows;
    logic [2:0]  depth_code;
    logic        disp_enable, pix_bgr, be_bytes, be_pixels;
    logic [31:0] upper_base, lower_base;
    logic        invalidate;

    int total = 0;
    int bad = 0;
    bit run_cmp = 0;

    assign pal_rdata = 32'h5A00_0000 | 32'(pal_index);

    lcdc_regfile i_lcdc_regfile (
        .clk(clk), .rst_n(rst_n), .alt_layout(alt_layout),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pal_we(pal_we), .pal_index(pal_index), .pal_rdata(pal_rdata),
        .irq_event(irq_event), .irq(irq),
        .disp_cols(disp_cols), .disp_rows(disp_rows), .depth_code(depth_code),
        .disp_enable(disp_enable), .pix_bgr(pix_bgr), .be_bytes(be_bytes),
        .be_pixels(be_pixels), .upper_base(upper_base), .lower_base(lower_base),
        .invalidate(invalidate)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference
    logic [31:0] m_tim [4];
    logic [31:0] m_up, m_lp, m_ctrl;
    logic [NIRQ-1:0] m_mask, m_raw;
    int m_cols, m_rows;
    bit m_inv;
    byte unsigned id_a [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    byte unsigned id_b [8] = '{8'h11, 8'h11, 8'h24, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_tim[i] = '0;
            m_up = '0; m_lp = '0; m_ctrl = '0; m_mask = '0; m_raw = '0;
            m_cols = 0; m_rows = 0; m_inv = 0;
        end else begin
            logic [NIRQ-1:0] clr;
            int w;
            clr = '0;
            w = int'(bus_addr) / 4;
            m_inv = bus_sel && bus_wr;
            if (bus_sel && bus_wr) begin
                if (w <= 3) m_tim[w] = bus_wdata;
                if (w == 0) m_cols = (int'(bus_wdata & 32'hFC) + 4) * 4;
                if (w == 1) m_rows = int'(bus_wdata & 32'h3FF) + 1;
                if (w == 4) m_up = bus_wdata;
                if (w == 5) m_lp = bus_wdata;
                if ((w == 6 && !alt_layout) || (w == 7 && alt_layout)) m_mask = bus_wdata[NIRQ-1:0];
                if ((w == 7 && !alt_layout) || (w == 6 && alt_layout)) m_ctrl = bus_wdata;
                if (w == 10) clr = bus_wdata[NIRQ-1:0];
            end
            m_raw = (m_raw & ~clr) | irq_event;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        int w;
        w = int'(a) / 4;
        if (a >= 12'hFE0) return 32'(alt_layout ? id_b[a[4:2]] : id_a[a[4:2]]);
        if (a >= 12'h200 && a <= 12'h3FF) return 32'h5A00_0000 | 32'(a[8:2]);
        case (w)
            0, 1, 2, 3: return m_tim[w];
            4, 11:      return m_up;
            5, 12:      return m_lp;
            6:          return alt_layout ? m_ctrl : 32'(m_mask);
            7:          return alt_layout ? 32'(m_mask) : m_ctrl;
            8:          return 32'(m_raw);
            9:          return 32'(m_raw & m_mask);
            default:    return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (run_cmp && rst_n) begin
            chk("R5 cols", 32'(disp_cols), 32'(m_cols));
            chk("R6 rows", 32'(disp_rows), 32'(m_rows));
            chk("R7 depth", 32'(depth_code), 32'(m_ctrl[3:1]));
            chk("R7 enable", 32'(disp_enable), 32'(m_ctrl[0] & m_ctrl[11]));
            chk("R7 flags", {29'b0, be_pixels, be_bytes, pix_bgr}, 32'(m_ctrl[10:8]));
            chk("R9 irq", 32'(irq), 32'(|(m_raw & m_mask)));
            chk("R12 invalidate", 32'(invalidate), 32'(m_inv));
            chk("R2 upper_base", upper_base, m_up);
            chk("R2 lower_base", lower_base, m_lp);
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        #2;
        if (a >= 12'h200 && a <= 12'h3FF) begin
            chk("R11 pal_we on write", 32'(pal_we), 32'h1);
            chk("R11 pal_index", 32'(pal_index), 32'(a[8:2]));
        end else begin
            chk("R11 pal_we outside range", 32'(pal_we), 32'h0);
        end
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #2;
        chk(tag, bus_rdata, exp_rd(a));
        if (a >= 12'h200 && a <= 12'h3FF) chk("R11 pal_we on read", 32'(pal_we), 32'h0);
        bus_sel = 0;
    endtask

    task automatic rd_const(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #2;
        chk(tag, bus_rdata, e);
        bus_sel = 0;
    endtask

    task automatic pulse_ev(input logic [NIRQ-1:0] v);
        @(negedge clk);
        irq_event = v;
        @(negedge clk);
        irq_event = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired (all requirements) act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        run_cmp = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cols", 32'(disp_cols), 0);
        chk("R1 rows", 32'(disp_rows), 0);
        chk("R1 enable/irq/inval", {29'b0, disp_enable, irq, invalidate}, 0);
        chk("R1 depth", 32'(depth_code), 0);
        for (int w = 0; w <= 12; w++) rd_const(12'(w * 4), 32'h0, "R1 reg zero");

        // R5 column formula
        wr(12'h000, 32'h0000_0013);
        chk("R5 cols 0x13", 32'(disp_cols), 80);
        chk("R12 pulse after write", 32'(invalidate), 1);
        @(negedge clk);
        chk("R12 pulse one cycle", 32'(invalidate), 0);
        wr(12'h000, 32'hFFFF_FFFF);
        chk("R5 cols max", 32'(disp_cols), 1024);
        wr(12'h000, 32'h0000_0003);
        chk("R5 cols low bits ignored", 32'(disp_cols), 16);
        rd(12'h000, "R2 timing0");

        // R6 row formula
        wr(12'h004, 32'h0000_01DF);
        chk("R6 rows 480", 32'(disp_rows), 480);
        wr(12'h004, 32'hFFFF_FC00);
        chk("R6 rows min", 32'(disp_rows), 1);
        wr(12'h004, 32'h0000_03FF);
        chk("R6 rows max", 32'(disp_rows), 1024);
        wr(12'h008, 32'h1234_5678);
        chk("R6 rows hold", 32'(disp_rows), 1024);
        wr(12'h00C, 32'h89AB_CDEF);
        wr(12'h010, 32'h0010_0000);
        wr(12'h014, 32'h0020_0004);
        for (int w = 0; w <= 5; w++) rd(12'(w * 4), "R2 readback");
        rd_const(12'h010, 32'h0010_0000, "R2 upper base");

        // R3 mirrors and ignored writes
        rd_const(12'h02C, 32'h0010_0000, "R3 upper current");
        rd_const(12'h030, 32'h0020_0004, "R3 lower current");
        wr(12'h02C, 32'hDEAD_BEEF);
        wr(12'h030, 32'hDEAD_BEEF);
        wr(12'h020, 32'h0000_001F);
        wr(12'h024, 32'h0000_001F);
        wr(12'h034, 32'hFFFF_FFFF);
        chk("R12 pulse undefined write", 32'(invalidate), 1);
        wr(12'h100, 32'hFFFF_FFFF);
        wr(12'hFDC, 32'hFFFF_FFFF);
        rd_const(12'h02C, 32'h0010_0000, "R3 mirror after write");
        rd_const(12'h020, 32'h0, "R3 raw unaffected");
        for (int a = 12'h034; a <= 12'h1FC; a += 12'h64) rd_const(12'(a), 32'h0, "R3 undefined zero");
        rd_const(12'hFDC, 32'h0, "R3 undefined zero top");
        rd_const(12'h028, 32'h0, "R3 clear reads zero");

        // R7 control fields, basic layout
        wr(12'h01C, 32'h0000_0807);
        chk("R7 enable on", 32'(disp_enable), 1);
        chk("R7 depth 3", 32'(depth_code), 3);
        wr(12'h01C, 32'h0000_0001);
        chk("R7 enable needs power", 32'(disp_enable), 0);
        wr(12'h01C, 32'h0000_0700);
        chk("R7 flags", {29'b0, be_pixels, be_bytes, pix_bgr}, 32'h7);
        wr(12'h01C, 32'h0000_090B);
        wr(12'h018, 32'h0000_0005);
        rd_const(12'h018, 32'h5, "R4 basic mask at 6");
        rd_const(12'h01C, 32'h0000_090B, "R4 basic ctrl at 7");

        // R8/R9 events, mask, clear
        pulse_ev(5'b00101);
        rd_const(12'h020, 32'h5, "R8 raw set");
        rd_const(12'h024, 32'h5, "R9 masked");
        chk("R9 irq high", 32'(irq), 1);
        wr(12'h018, 32'h0000_0002);
        rd_const(12'h024, 32'h0, "R9 masked none");
        chk("R9 irq low", 32'(irq), 0);
        pulse_ev(5'b10010);
        rd_const(12'h020, 32'h17, "R8 raw accumulates");
        rd(12'h024, "R9 masked partial");
        wr(12'h028, 32'h0000_0001);
        rd_const(12'h020, 32'h16, "R8 partial clear");
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 12'h028; bus_wdata = 32'h1F; irq_event = 5'b00100;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; irq_event = '0;
        rd_const(12'h020, 32'h4, "R8 set wins over clear");

        // R10 identification, basic layout
        for (int i = 0; i < 8; i++) rd_const(12'(12'hFE0 + i * 4), 32'(id_a[i]), "R10 id basic");

        // R4 alternate layout
        @(negedge clk);
        alt_layout = 1;
        rd_const(12'h018, 32'h0000_090B, "R4 alt ctrl at 6");
        rd_const(12'h01C, 32'h2, "R4 alt mask at 7");
        wr(12'h018, 32'h0000_0801);
        chk("R4 alt ctrl write", 32'(disp_enable), 1);
        wr(12'h01C, 32'h0000_0004);
        chk("R9 irq via alt mask", 32'(irq), 1);
        rd(12'h018, "R4 alt read 6");
        rd(12'h01C, "R4 alt read 7");
        for (int i = 0; i < 8; i++) rd_const(12'(12'hFE0 + i * 4), 32'(id_b[i]), "R10 id alt");

        // R11 palette range
        wr(12'h200, 32'h0000_7FFF);
        wr(12'h3FC, 32'h0000_1234);
        rd(12'h2A8, "R11 palette read");
        rd_const(12'h3FC, 32'h5A00_007F, "R11 palette last");
        rd(12'h010, "R11 regs untouched by palette write");
        rd(12'h000, "R11 timing untouched");

        // R1 second reset with state populated
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        alt_layout = 0;
        @(negedge clk);
        chk("R1 cols after reset", 32'(disp_cols), 0);
        chk("R1 irq after reset", 32'(irq), 0);
        rd_const(12'h020, 32'h0, "R1 raw after reset");
        rd_const(12'h010, 32'h0, "R1 base after reset");

        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule